// File: doc/BRIEF.md
# Daisy-Chainable Serial Register Front End

This block is the serial control port of a converter-style device. A host talks to it over four wires: a serial clock, an active-low frame select, a data input and a data output. While select is low, every falling edge of the serial clock moves one bit from the data input into a 32-bit shift register. Bits that drop out of the top of that register are presented on the data output, so that several devices can share one select line with the output of each device wired to the input of the next.

When select rises, the block checks that the number of serial clocks was a whole number of 32-bit frames. If it was, the block decodes the most recent 32 bits into a write to a small register file. If it was not, the block throws the frame away and sets a sticky error flag. The register file holds a converter data word, two configuration words, a clear-level data word, a trigger word and a status word. The data word drives the converter through a code output and a one-cycle load strobe.

All serial pins are oversampled by the system clock through synchronizer chains, so the register file and its outputs live entirely in the system clock domain. One configuration bit moves the launch of the data output from the rising serial clock edge to the falling one, which gives a downstream device half a serial period more margin.

Top module: `spi_chain_regif`

## Requirements
- R1: After reset, dac_code, clr_code, trig_word, frame_err, dac_load and spi_sdo are all zero. cfg_main is 24'h004C80 and cfg_aux is 24'h000040.
- R2: A frame is 32 bits sent most significant bit first. Bit 31 is a read flag (0 means write), bits 30:24 are a 7-bit register address and bits 23:0 are the payload. Each bit is sampled on a falling edge of spi_sclk while spi_cs_n is low.
- R3: A frame takes effect only on the rising edge of spi_cs_n, and only when at least 32 falling edges arrived and their count is a multiple of 32. The last 32 bits received are the frame that is decoded.
- R4: A write to address 01h places the payload on dac_code. dac_load is high for exactly one system clock, in the same cycle in which dac_code takes the new value. No other write pulses dac_load.
- R5: A write to address 02h sets cfg_main, 03h sets clr_code, 04h sets trig_word and 06h sets cfg_aux, each to the full 24-bit payload.
- R6: A write to address 00h, a write to any address of 07h or above, and any frame with bit 31 set leave every register output unchanged.
- R7: When select rises after a number of falling edges that is not a positive multiple of 32, no register is written and frame_err is set. frame_err stays set afterwards.
- R8: A write to address 05h with payload bit 0 set clears frame_err. The same write with bit 0 clear leaves frame_err unchanged.
- R9: When cfg_main bit 13 is 0, spi_sdo changes only after a rising spi_sclk edge. Just before falling edge number m, with m greater than 32, it shows bit number m-32 of the stream.
- R10: When cfg_main bit 13 is 1, spi_sdo changes after each falling edge. In the low phase after falling edge m (32 ≤ m), it already shows stream bit m-31.
- R11: Edges on spi_sclk while spi_cs_n is high do not shift data, do not count toward the frame length and do not change spi_sdo.
- R12: If select rises in the same cycle as a rising spi_sclk edge, the frame commits from the bits sampled up to the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data in, sampled on falling serial clock edges |
| spi_sdo | output | 1 | Serial data out toward the next device in the chain |
| dac_code | output | 24 | Converter data word |
| dac_load | output | 1 | One-cycle strobe marking a new converter data word |
| cfg_main | output | 24 | Main configuration word; bit 13 selects early data-out launch |
| cfg_aux | output | 24 | Auxiliary configuration word |
| clr_code | output | 24 | Clear-level data word |
| trig_word | output | 24 | Trigger word |
| frame_err | output | 1 | Sticky flag for a frame of bad length |

## Verification
The frame commit and the normal-mode launch of the data output can fall in the same system clock cycle. This happens when the host raises select together with the serial clock after the last bit. The bench provokes this by driving both pins in the same step. It judges the outcome by the converter word that the scoreboard pops on the load strobe, which must equal the frame that was shifted in. A second pairing is checked through the output pin itself: the shift on a falling edge and the early (fast-mode) launch share one cycle. The bench compares the data output in the low phase against the bit that the next falling edge will evict.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
   // register address map, decoded from frame bits [30:24]
   localparam int ADR_NOP   = 0;
   localparam int ADR_DATA  = 1;
   localparam int ADR_CFG1  = 2;
   localparam int ADR_CLR   = 3;
   localparam int ADR_TRIG  = 4;
   localparam int ADR_STAT  = 5;
   localparam int ADR_CFG2  = 6;
   localparam int NUM_REGS  = 7;
   // status register: write-one-to-clear error bit
   localparam int ERR_BIT   = 0;
   // registers backed by plain storage (status and no-op are special)
   localparam logic [NUM_REGS-1:0] STORE_MASK = 7'b101_1110;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic sdi,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_rise,
   output logic cs_fall,
   output logic cs_active,
   output logic sdi_q
);
   // bit 0 sclk, bit 1 cs_n, bit 2 sdi
   localparam logic [2:0] IDLE_VEC = 3'b010;

   if (STAGES < 1) begin : g_bad_stages
      $error("spi_edge_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][2:0] chain;
   logic [1:0]             prev;
   logic [2:0]             last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_VEC;
         prev <= IDLE_VEC[1:0];
      end else begin
         chain[0] <= {sdi, cs_n, sclk};
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         prev <= chain[STAGES-1][1:0];
      end
   end

   assign last      = chain[STAGES-1];
   assign sclk_rise =  last[0] & ~prev[0];
   assign sclk_fall = ~last[0] &  prev[0];
   assign cs_rise   =  last[1] & ~prev[1];
   assign cs_fall   = ~last[1] &  prev[1];
   assign cs_active = ~last[1];
   assign sdi_q     =  last[2];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
   parameter int FRAME_W     = 32,
   parameter bit FAST_SDO_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_rise,
   input  logic               sclk_fall,
   input  logic               cs_rise,
   input  logic               cs_fall,
   input  logic               cs_active,
   input  logic               sdi,
   input  logic               fast_sdo,
   output logic               sdo,
   output logic [FRAME_W-1:0] frame_word,
   output logic               frame_ok,
   output logic               frame_bad
);
   localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
   localparam int MSB   = FRAME_W - 1;

   if (FRAME_W < 2) begin : g_bad_frame
      $error("spi_shifter: FRAME_W must be at least 2");
   end

   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   cnt;
   logic               full;
   logic               shift_en;
   logic               sdo_q;

   assign shift_en = cs_active & sclk_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (shift_en) begin
         shreg <= {shreg[MSB-1:0], sdi};
      end
   end

   // bit counter modulo the frame width; full marks one whole frame seen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         full <= 1'b0;
      end else if (cs_fall) begin
         cnt  <= '0;
         full <= 1'b0;
      end else if (shift_en) begin
         if (cnt == CNT_W'(FRAME_W - 1)) begin
            cnt  <= '0;
            full <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_word <= '0;
         frame_ok   <= 1'b0;
         frame_bad  <= 1'b0;
      end else begin
         frame_ok  <= cs_rise &  (full & (cnt == '0));
         frame_bad <= cs_rise & ~(full & (cnt == '0));
         if (cs_rise) frame_word <= shreg;
      end
   end

   if (FAST_SDO_EN) begin : g_sdo_dual
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sdo_q <= 1'b0;
         end else if (fast_sdo) begin
            if (cs_fall)       sdo_q <= shreg[MSB];
            else if (shift_en) sdo_q <= shreg[MSB-1];
         end else if (cs_active && sclk_rise) begin
            sdo_q <= shreg[MSB];
         end
      end

      // R10
      sdo_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fast_sdo && !sclk_fall && !cs_fall) |=> $stable(sdo_q))
         else $error("fast-mode data out moved without a falling edge");
   end else begin : g_sdo_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      sdo_q <= 1'b0;
         else if (cs_active && sclk_rise) sdo_q <= shreg[MSB];
      end
   end

   assign sdo = sdo_q;

   // R11
   shreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |=> $stable(shreg))
      else $error("shift register moved while deselected");

   // R9
   sdo_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_sdo && !sclk_rise) |=> $stable(sdo_q))
      else $error("normal-mode data out moved without a rising edge");

   // R3
   commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> !frame_ok)
      else $error("frame committed twice for one select edge");
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
   import spi_chain_pkg::*;
#(
   parameter int                FRAME_W  = 32,
   parameter int                ADDR_W   = 7,
   parameter int                DATA_W   = 24,
   parameter logic [DATA_W-1:0] CFG1_RST = 24'h004C80,
   parameter logic [DATA_W-1:0] CFG2_RST = 24'h000040,
   parameter int                FAST_BIT = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_ok,
   input  logic               frame_bad,
   input  logic [FRAME_W-1:0] frame_word,
   output logic [DATA_W-1:0]  dac_code,
   output logic               dac_load,
   output logic [DATA_W-1:0]  cfg_main,
   output logic [DATA_W-1:0]  cfg_aux,
   output logic [DATA_W-1:0]  clr_code,
   output logic [DATA_W-1:0]  trig_word,
   output logic               frame_err,
   output logic               fast_sdo
);
   if (FRAME_W != 1 + ADDR_W + DATA_W) begin : g_bad_split
      $error("spi_regfile: FRAME_W must equal 1 + ADDR_W + DATA_W");
   end
   if (FAST_BIT >= DATA_W || ADDR_W < 3) begin : g_bad_field
      $error("spi_regfile: FAST_BIT or ADDR_W out of range");
   end

   logic              frame_rd;
   logic [ADDR_W-1:0] frame_addr;
   logic [DATA_W-1:0] payload;
   logic              wr_en;
   logic [DATA_W-1:0] reg_q [NUM_REGS];

   assign frame_rd   = frame_word[FRAME_W-1];
   assign frame_addr = frame_word[FRAME_W-2 -: ADDR_W];
   assign payload    = frame_word[DATA_W-1:0];
   assign wr_en      = frame_ok & ~frame_rd;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      if (STORE_MASK[k]) begin : g_store
         localparam logic [DATA_W-1:0] RST_VAL =
            (k == ADR_CFG1) ? CFG1_RST :
            (k == ADR_CFG2) ? CFG2_RST : '0;
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   q <= RST_VAL;
            else if (wr_en && frame_addr == ADDR_W'(k))   q <= payload;
         end
         assign reg_q[k] = q;
      end else begin : g_none
         assign reg_q[k] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dac_load <= 1'b0;
      else        dac_load <= wr_en && (frame_addr == ADDR_W'(ADR_DATA));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frame_err <= 1'b0;
      else if (frame_bad)
         frame_err <= 1'b1;
      else if (wr_en && frame_addr == ADDR_W'(ADR_STAT) && payload[ERR_BIT])
         frame_err <= 1'b0;
   end

   assign dac_code  = reg_q[ADR_DATA];
   assign cfg_main  = reg_q[ADR_CFG1];
   assign clr_code  = reg_q[ADR_CLR];
   assign trig_word = reg_q[ADR_TRIG];
   assign cfg_aux   = reg_q[ADR_CFG2];
   assign fast_sdo  = cfg_main[FAST_BIT];

   // R4
   load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_load |=> !dac_load)
      else $error("load strobe longer than one cycle");

   // R4
   load_pairs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_load |-> $stable(dac_code))
      else $error("data word changed without a load strobe");

   // R6
   nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok && (frame_rd || frame_addr == '0)) |=>
         ($stable(dac_code) && $stable(cfg_main) && $stable(cfg_aux) &&
          $stable(clr_code) && $stable(trig_word) && !dac_load))
      else $error("ignored frame changed a register");

   // R7
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_bad |=> frame_err)
      else $error("bad-length frame did not raise the error flag");
endmodule

// File: rtl/spi_chain_regif.sv
module spi_chain_regif #(
   parameter int                FRAME_W     = 32,
   parameter int                ADDR_W      = 7,
   parameter int                DATA_W      = 24,
   parameter int                SYNC_STAGES = 2,
   parameter bit                FAST_SDO_EN = 1'b1,
   parameter logic [DATA_W-1:0] CFG1_RST    = 24'h004C80,
   parameter logic [DATA_W-1:0] CFG2_RST    = 24'h000040,
   parameter int                FAST_BIT    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_sdi,
   output logic              spi_sdo,
   output logic [DATA_W-1:0] dac_code,
   output logic              dac_load,
   output logic [DATA_W-1:0] cfg_main,
   output logic [DATA_W-1:0] cfg_aux,
   output logic [DATA_W-1:0] clr_code,
   output logic [DATA_W-1:0] trig_word,
   output logic              frame_err
);
   logic               sclk_rise, sclk_fall, cs_rise, cs_fall, cs_active, sdi_q;
   logic               fast_sdo, frame_ok, frame_bad;
   logic [FRAME_W-1:0] frame_word;

   spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk      (spi_sclk),
      .cs_n      (spi_cs_n),
      .sdi       (spi_sdi),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_rise   (cs_rise),
      .cs_fall   (cs_fall),
      .cs_active (cs_active),
      .sdi_q     (sdi_q)
   );

   spi_shifter #(.FRAME_W(FRAME_W), .FAST_SDO_EN(FAST_SDO_EN)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_rise  (sclk_rise),
      .sclk_fall  (sclk_fall),
      .cs_rise    (cs_rise),
      .cs_fall    (cs_fall),
      .cs_active  (cs_active),
      .sdi        (sdi_q),
      .fast_sdo   (fast_sdo),
      .sdo        (spi_sdo),
      .frame_word (frame_word),
      .frame_ok   (frame_ok),
      .frame_bad  (frame_bad)
   );

   spi_regfile #(
      .FRAME_W  (FRAME_W),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CFG1_RST (CFG1_RST),
      .CFG2_RST (CFG2_RST),
      .FAST_BIT (FAST_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_ok   (frame_ok),
      .frame_bad  (frame_bad),
      .frame_word (frame_word),
      .dac_code   (dac_code),
      .dac_load   (dac_load),
      .cfg_main   (cfg_main),
      .cfg_aux    (cfg_aux),
      .clr_code   (clr_code),
      .trig_word  (trig_word),
      .frame_err  (frame_err),
      .fast_sdo   (fast_sdo)
   );
endmodule

// File: tb/spi_chain_regif_bench.sv
module spi_chain_regif_bench;
   localparam int H = 6;   // system clocks per serial half period

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sclk = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_sdi = 1'b0;
   logic        spi_sdo;
   logic [23:0] dac_code, cfg_main, cfg_aux, clr_code, trig_word;
   logic        dac_load, frame_err;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   bit  prev_load = 1'b0;
   logic [23:0] exp_q [$];

   always #2 clk = ~clk;   // 250 MHz

   spi_chain_regif u_spi_chain_regif (
      .clk (clk), .rst_n (rst_n),
      .spi_sclk (spi_sclk), .spi_cs_n (spi_cs_n), .spi_sdi (spi_sdi),
      .spi_sdo (spi_sdo), .dac_code (dac_code), .dac_load (dac_load),
      .cfg_main (cfg_main), .cfg_aux (cfg_aux), .clr_code (clr_code),
      .trig_word (trig_word), .frame_err (frame_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit rd, input logic [6:0] a, input logic [23:0] d);
      return {rd, a, d};
   endfunction

   task automatic wait_h(input int n);
      repeat (n) @(negedge clk);
   endtask

   // mode: 0 no data-out check, 1 normal launch, 2 early launch
   task automatic xfer(input int nbits, input logic [127:0] s, input int mode, input bit cs_with_rise);
      spi_cs_n = 1'b0;
      wait_h(H);
      for (int m = 1; m <= nbits; m++) begin
         spi_sclk = 1'b1;
         spi_sdi  = s[nbits-m];
         wait_h(H);
         if (mode != 0 && m > 32)
            chk(spi_sdo == s[nbits-(m-32)], "R9 sdo before fall", 32'(spi_sdo), 32'(s[nbits-(m-32)]));
         spi_sclk = 1'b0;
         wait_h(H);
         if (mode == 1 && m > 32)
            chk(spi_sdo == s[nbits-(m-32)], "R9 sdo low phase", 32'(spi_sdo), 32'(s[nbits-(m-32)]));
         if (mode == 2 && m >= 32 && m < nbits)
            chk(spi_sdo == s[nbits-(m-31)], "R10 early sdo", 32'(spi_sdo), 32'(s[nbits-(m-31)]));
      end
      if (cs_with_rise) spi_sclk = 1'b1;
      spi_cs_n = 1'b1;
      wait_h(2 * H);
      spi_sclk = 1'b0;
      wait_h(H);
   endtask

   task automatic write1(input logic [6:0] a, input logic [23:0] d);
      if (a == 7'h01) exp_q.push_back(d);
      xfer(32, 128'(mk(1'b0, a, d)), 0, 1'b0);
   endtask

   // scoreboard monitor for the load strobe
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (dac_load) begin
            chk(!prev_load, "R4 strobe width", 32'(prev_load), 32'd0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected load", {8'h0, dac_code}, 32'hFFFFFFFF);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               chk(dac_code == e, "R4 loaded word", {8'h0, dac_code}, {8'h0, e});
            end
         end
         prev_load = dac_load;
      end
   end

   task automatic snap_same(input string tag, input logic [23:0] d, c1, c2, cl, tr);
      chk(dac_code == d,  tag, {8'h0, dac_code},  {8'h0, d});
      chk(cfg_main == c1, tag, {8'h0, cfg_main},  {8'h0, c1});
      chk(cfg_aux == c2,  tag, {8'h0, cfg_aux},   {8'h0, c2});
      chk(clr_code == cl, tag, {8'h0, clr_code},  {8'h0, cl});
      chk(trig_word == tr, tag, {8'h0, trig_word}, {8'h0, tr});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic sdo_hold;
      wait_h(5);
      rst_n = 1'b1;
      wait_h(3);
      // R1 reset state
      snap_same("R1 reset", 24'h0, 24'h004C80, 24'h000040, 24'h0, 24'h0);
      chk(frame_err == 1'b0, "R1 reset err", 32'(frame_err), 0);
      chk(spi_sdo == 1'b0 && dac_load == 1'b0, "R1 reset sdo/load", {spi_sdo, dac_load}, 0);

      // R2 single frame write
      write1(7'h01, 24'hABCDE5);
      chk(dac_code == 24'hABCDE5, "R2 data write", {8'h0, dac_code}, 32'hABCDE5);

      // R5 other writable registers
      write1(7'h06, 24'h123456);
      write1(7'h03, 24'h0F0F0F);
      write1(7'h04, 24'h000003);
      snap_same("R5 config writes", 24'hABCDE5, 24'h004C80, 24'h123456, 24'h0F0F0F, 24'h000003);

      // R3 and R9: two-frame chain, last 32 bits commit, data out in normal mode
      exp_q.push_back(24'h5A5A5A);
      xfer(64, {64'h0, mk(1'b0, 7'h01, 24'hC33C96), mk(1'b0, 7'h01, 24'h5A5A5A)}, 1, 1'b0);
      chk(dac_code == 24'h5A5A5A, "R3 chain commit", {8'h0, dac_code}, 32'h5A5A5A);

      // R6 ignored frames
      write1(7'h00, 24'hFFFFFF);
      write1(7'h07, 24'h111111);
      write1(7'h7F, 24'h222222);
      xfer(32, 128'(mk(1'b1, 7'h01, 24'h333333)), 0, 1'b0);
      snap_same("R6 ignored", 24'h5A5A5A, 24'h004C80, 24'h123456, 24'h0F0F0F, 24'h000003);

      // R7 bad lengths
      xfer(20, 128'(20'hABCDE), 0, 1'b0);
      chk(frame_err == 1'b1, "R7 short frame flag", 32'(frame_err), 1);
      xfer(40, 128'(40'h0204442424), 0, 1'b0);
      snap_same("R7 discarded", 24'h5A5A5A, 24'h004C80, 24'h123456, 24'h0F0F0F, 24'h000003);
      chk(frame_err == 1'b1, "R7 sticky flag", 32'(frame_err), 1);

      // R8 write-one-to-clear
      write1(7'h05, 24'h000002);
      chk(frame_err == 1'b1, "R8 zero bit keeps flag", 32'(frame_err), 1);
      write1(7'h05, 24'h000001);
      chk(frame_err == 1'b0, "R8 one bit clears flag", 32'(frame_err), 0);

      // R11 clocks while deselected
      sdo_hold = spi_sdo;
      spi_sdi = 1'b1;
      for (int i = 0; i < 8; i++) begin
         spi_sclk = 1'b1; wait_h(H);
         spi_sclk = 1'b0; wait_h(H);
      end
      chk(spi_sdo == sdo_hold, "R11 sdo idle", 32'(spi_sdo), 32'(sdo_hold));
      write1(7'h01, 24'h000777);
      chk(dac_code == 24'h000777 && frame_err == 1'b0, "R11 count untouched",
          {7'h0, frame_err, dac_code}, 32'h000777);

      // R10 early launch mode
      write1(7'h02, 24'h006C80);
      chk(cfg_main == 24'h006C80, "R5 cfg_main write", {8'h0, cfg_main}, 32'h006C80);
      exp_q.push_back(24'h2468AC);
      xfer(64, {64'h0, mk(1'b0, 7'h06, 24'hA5A5A5), mk(1'b0, 7'h01, 24'h2468AC)}, 2, 1'b0);
      chk(dac_code == 24'h2468AC, "R10 chain commit", {8'h0, dac_code}, 32'h2468AC);
      write1(7'h02, 24'h004C80);

      // R12 select rises together with the serial clock
      exp_q.push_back(24'h13579B);
      xfer(32, 128'(mk(1'b0, 7'h01, 24'h13579B)), 0, 1'b1);
      chk(dac_code == 24'h13579B, "R12 coincident commit", {8'h0, dac_code}, 32'h13579B);

      wait_h(10);
      chk(exp_q.size() == 0, "R4 all loads seen", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule